// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers the single-cycle event strobes from an SD/MMC host's command and data engines. It stores them in a sticky raw status register. The raw status is ANDed with a software mask to form a masked status. A global enable turns a non-empty masked status into one interrupt line towards the CPU.

Two summary flags come from the masked status:
- one flag for any error-class event;
- one flag for any completion-class event.

The card-insert and card-remove sources are asynchronous levels. They pass through a synchroniser before capture.

Software reaches the block over a plain 32-bit register bus with the following map:

| Offset | Register | Access |
|---|---|---|
| 0x00 | control | global enable plus the host reset bits |
| 0x30 | mask | read/write |
| 0x34 | masked status | read-only |
| 0x38 | raw status | read, write-one-to-clear |

Reads return data one clock after the request.

Top module: `sdh_irq_stat`

## Requirements
- R1: After reset, the following are all zero: raw status, mask, masked status and the control register, and `irq_o`, `err_any_o` and `done_any_o` are low.
- R2: A pulse on `ev_i[k]` sets raw bit k+1 (raw bits 1..16) at the next clock edge. The bit stays set until it is cleared. Raw bit 0 and bits 17..29 always read zero.
- R3: A high level on `card_ins_i` or `card_rem_i` sets raw bit 30 or raw bit 31. The bit shows at the third rising edge after the input rises: two synchroniser flops, then the raw register.
- R4: The mask at 0x30 reads back what was written. The masked status at 0x34 reads raw AND mask.
- R5: A write to 0x38 clears each raw bit whose data bit is one. Raw bits whose data bit is zero are left unchanged.
- R6: When an event and a clearing write hit the same raw bit in the same cycle, the bit stays set.
- R7: `irq_o` is high exactly when control bit 4 (global enable) is set and the masked status is non-zero.
- R8: `err_any_o` is the OR of the masked status bits in the error group 0x0000BBC2 (bits 1, 6, 7, 8, 9, 11, 12, 13 and 15). Other masked bits do not raise it.
- R9: `done_any_o` is the OR of the masked status bits in the completion group 0x0000440C (bits 2, 3, 10 and 14).
- R10: The host reset clears all raw status.
  - It is a write to 0x00 with bits 0, 1 and 2 all one.
  - It wins over events in the same cycle.
  - A write with only some of bits 0..2 set clears nothing.
  - Bits 0..2 read back as zero.
  - Bit 4 of the same write is stored.
- R11: Read data appears one cycle after the request and holds otherwise. Writes to 0x34 are ignored. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_i | input | 16 | Event strobes for raw bits 16..1 |
| card_ins_i | input | 1 | Asynchronous card-inserted level |
| card_rem_i | input | 1 | Asynchronous card-removed level |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after a read |
| irq_o | output | 1 | Interrupt to the CPU |
| err_any_o | output | 1 | Any masked error event |
| done_any_o | output | 1 | Any masked completion event |

## Verification
A wrong raw or mask bit shows at `irq_o` and at the two summary flags in the same cycle the register takes the bad value. It also shows in the next raw or masked read, one cycle after the read request.

A slip in the synchroniser depth moves the card-event interrupt by whole cycles. The bench therefore samples it at each of the three edges. Priority faults only show in the cycle of the collision, so a read right after that cycle exposes them:
- a clear that beats a new event;
- an event that survives a host reset.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int unsigned REG_W = 32;

  // register offsets (bytes)
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_MASK  = 'h30;
  localparam int unsigned OFS_MSTAT = 'h34;
  localparam int unsigned OFS_RAW   = 'h38;

  // control register fields
  localparam int unsigned CTRL_GIE    = 4;
  localparam int unsigned CTRL_RST_HI = 2;

  // raw status layout
  localparam int unsigned EV_LO    = 1;
  localparam int unsigned EV_W     = 16;
  localparam int unsigned CARD_INS = 30;
  localparam int unsigned CARD_REM = 31;

  localparam logic [REG_W-1:0] ERR_GROUP  = 32'h0000_BBC2;
  localparam logic [REG_W-1:0] DONE_GROUP = 32'h0000_440C;
  localparam logic [REG_W-1:0] RSVD_BITS  = 32'h3FFE_0001;
endpackage

// File: rtl/sdh_irq_sync.sv
module sdh_irq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdh_irq_raw.sv
module sdh_irq_raw
  import sdh_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  input  logic             hrst_i,
  output logic [REG_W-1:0] raw_o
);
  logic [REG_W-1:0] raw_q, raw_d;
  logic             raw_en;

  // priority: host reset, then new events, then software clear
  always_comb begin
    raw_en = hrst_i | (|set_i) | (|clr_i);
    if (hrst_i) raw_d = '0;
    else        raw_d = (raw_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  // R6: a new event always lands, even against a clear
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hrst_i && set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));
  // R5: cleared bits drop when no event targets them
  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hrst_i && clr_i != '0 && (set_i & clr_i) == '0) |=> ((raw_o & $past(clr_i)) == '0));
  // R2: without clear or reset, set bits are sticky
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hrst_i && clr_i == '0) |=> ((raw_o & $past(raw_o)) == $past(raw_o)));
  // R10: host reset empties the register
  a_r10_hrst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrst_i |=> (raw_o == '0));
  // R2: reserved positions never hold a one
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_o & RSVD_BITS) == '0));
endmodule

// File: rtl/sdh_irq_regif.sv
module sdh_irq_regif
  import sdh_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [REG_W-1:0]  raw_i,
  input  logic [REG_W-1:0]  masked_i,
  output logic [REG_W-1:0]  mask_o,
  output logic              gie_o,
  output logic [REG_W-1:0]  clr_o,
  output logic              hrst_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(OFS_MSTAT);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);

  logic [REG_W-1:0] mask_q, rdata_q, rdata_d;
  logic             gie_q;
  logic             wr_ctrl, wr_mask, wr_raw, rd_en;

  always_comb begin
    wr_ctrl = sel_i & wr_i & (addr_i == A_CTRL);
    wr_mask = sel_i & wr_i & (addr_i == A_MASK);
    wr_raw  = sel_i & wr_i & (addr_i == A_RAW);
    rd_en   = sel_i & ~wr_i;
    hrst_o  = wr_ctrl & (&wdata_i[CTRL_RST_HI:0]);
    clr_o   = wr_raw ? wdata_i : '0;
    rdata_d = '0;
    unique case (addr_i)
      A_CTRL:  rdata_d[CTRL_GIE] = gie_q;
      A_MASK:  rdata_d = mask_q;
      A_MSTAT: rdata_d = masked_i;
      A_RAW:   rdata_d = raw_i;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gie_q <= 1'b0;
    else if (wr_ctrl) gie_q <= wdata_i[CTRL_GIE];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign mask_o  = mask_q;
  assign gie_o   = gie_q;
  assign rdata_o = rdata_q;

  // R11: read data only moves on a read request
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !wr_i) |=> $stable(rdata_o));
  // R11: writes to the masked-status offset touch no state
  a_r11_ro_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == A_MSTAT) |=> ($stable(mask_o) && $stable(gie_o)));
  // R4: mask write lands
  a_r4_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == A_MASK) |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/sdh_irq_stat.sv
module sdh_irq_stat
  import sdh_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EV_W-1:0]   ev_i,
  input  logic              card_ins_i,
  input  logic              card_rem_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              err_any_o,
  output logic              done_any_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [1:0]       card_s;
  logic [REG_W-1:0] set_vec, clr_vec, raw, mask, masked;
  logic             hrst, gie;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sdh_irq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_card_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    ({card_rem_i, card_ins_i}),
    .q_o    (card_s)
  );

  always_comb begin
    set_vec                = '0;
    set_vec[EV_LO +: EV_W] = ev_i;
    set_vec[CARD_INS]      = card_s[0];
    set_vec[CARD_REM]      = card_s[1];
  end

  sdh_irq_raw u_raw (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .hrst_i (hrst),
    .raw_o  (raw)
  );

  sdh_irq_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .raw_i    (raw),
    .masked_i (masked),
    .mask_o   (mask),
    .gie_o    (gie),
    .clr_o    (clr_vec),
    .hrst_o   (hrst)
  );

  always_comb begin
    masked     = raw & mask;
    err_any_o  = |(masked & ERR_GROUP);
    done_any_o = |(masked & DONE_GROUP);
    irq_o      = gie & (|masked);
  end

  // R7: no interrupt while globally disabled
  a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !gie |-> !irq_o);
  // R8: error flag only with some masked bit present
  a_r8_err_needs_masked: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    err_any_o |-> (masked != '0));
  // R9: completion flag only with some masked bit present
  a_r9_done_needs_masked: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    done_any_o |-> (masked != '0));
  // R3: synchronised insert level is captured one edge later
  a_r3_card_capture: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (card_s[0] && !hrst) |=> raw[CARD_INS]);
endmodule

// File: tb/sdh_irq_stat_tb_top.sv
module sdh_irq_stat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev = '0;
  logic        card_ins = 1'b0, card_rem = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, err_any, done_any;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #2.5 clk = ~clk;

  sdh_irq_stat dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .card_ins_i(card_ins),
    .card_rem_i(card_rem), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .err_any_o(err_any), .done_any_o(done_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare returned read data against the scoreboard queue
  always @(posedge clk) rd_pend <= sel & ~wr;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) check("SB underflow", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic idle();
    sel = 0; wr = 0; ev = '0; addr = '0; wdata = '0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic [15:0] e);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d; ev = e;
    @(negedge clk); idle();
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); idle();
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); idle();
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle();
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 err", {31'd0, err_any}, 32'd0);
    check("R1 done", {31'd0, done_any}, 32'd0);
    rd_reg(8'h38, 32'h0, "R1 raw");
    rd_reg(8'h34, 32'h0, "R1 masked");
    rd_reg(8'h30, 32'h0, "R1 mask");
    rd_reg(8'h00, 32'h0, "R1 ctrl");

    // R2 event mapping and stickiness
    pulse(16'h8001);
    rd_reg(8'h38, 32'h0001_0002, "R2 raw set");
    wait_cyc(3);
    rd_reg(8'h38, 32'h0001_0002, "R2 sticky");

    // R4 mask and masked status; R8/R9/R7 flags
    wr_reg(8'h30, 32'h0000_0006, '0);
    rd_reg(8'h30, 32'h0000_0006, "R4 mask readback");
    rd_reg(8'h34, 32'h0000_0002, "R4 masked");
    check("R8 err on masked bit1", {31'd0, err_any}, 32'd1);
    check("R9 no done", {31'd0, done_any}, 32'd0);
    check("R7 irq gated off", {31'd0, irq}, 32'd0);
    wr_reg(8'h00, 32'h0000_0010, '0);
    check("R7 irq on", {31'd0, irq}, 32'd1);
    rd_reg(8'h00, 32'h0000_0010, "R7 ctrl readback");

    pulse(16'h0002);
    check("R9 done on cmd done", {31'd0, done_any}, 32'd1);
    rd_reg(8'h34, 32'h0000_0006, "R4 masked two bits");

    // R5 write-one-to-clear
    wr_reg(8'h38, 32'h0000_0002, '0);
    check("R5 err cleared", {31'd0, err_any}, 32'd0);
    rd_reg(8'h38, 32'h0001_0004, "R5 one clears");
    wr_reg(8'h38, 32'h0000_0000, '0);
    rd_reg(8'h38, 32'h0001_0004, "R5 zero keeps");

    // R6 event beats clear
    wr_reg(8'h38, 32'h0000_0004, 16'h0002);
    rd_reg(8'h38, 32'h0001_0004, "R6 event wins");
    wr_reg(8'h38, 32'h0000_0004, '0);
    check("R7 irq off when masked empty", {31'd0, irq}, 32'd0);
    check("R9 done off", {31'd0, done_any}, 32'd0);

    // R11 read-only and unmapped
    wr_reg(8'h34, 32'hFFFF_FFFF, '0);
    rd_reg(8'h30, 32'h0000_0006, "R11 masked write ignored");
    rd_reg(8'h34, 32'h0000_0000, "R11 masked unchanged");
    rd_reg(8'h3C, 32'h0000_0000, "R11 unmapped");

    // R3 card insert through synchroniser
    wr_reg(8'h38, 32'hFFFF_FFFF, '0);
    wr_reg(8'h30, 32'h4000_0000, '0);
    check("R3 irq before", {31'd0, irq}, 32'd0);
    @(negedge clk); card_ins = 1'b1;
    @(negedge clk); check("R3 edge1", {31'd0, irq}, 32'd0);
    @(negedge clk); check("R3 edge2", {31'd0, irq}, 32'd0);
    @(negedge clk); check("R3 edge3", {31'd0, irq}, 32'd1);
    card_ins = 1'b0;
    wait_cyc(4);
    wr_reg(8'h38, 32'h4000_0000, '0);
    rd_reg(8'h38, 32'h0000_0000, "R3 insert cleared");
    @(negedge clk); card_rem = 1'b1;
    wait_cyc(4);
    card_rem = 1'b0;
    rd_reg(8'h38, 32'h8000_0000, "R3 remove captured");
    wait_cyc(4);
    wr_reg(8'h38, 32'h8000_0000, '0);

    // R10 host reset
    pulse(16'h0401);
    wr_reg(8'h00, 32'h0000_0011, '0);
    rd_reg(8'h38, 32'h0000_0802, "R10 partial reset keeps");
    wr_reg(8'h00, 32'h0000_0017, '0);
    rd_reg(8'h38, 32'h0000_0000, "R10 full reset clears");
    rd_reg(8'h00, 32'h0000_0010, "R10 reset bits read zero");
    wr_reg(8'h00, 32'h0000_0017, 16'h0001);
    rd_reg(8'h38, 32'h0000_0000, "R10 reset beats event");

    // R9 auto-command done; R8 non-error bit
    wr_reg(8'h30, 32'h0000_4420, '0);
    pulse(16'h2000);
    check("R9 done on auto cmd", {31'd0, done_any}, 32'd1);
    check("R8 no err on auto cmd", {31'd0, err_any}, 32'd0);
    wr_reg(8'h38, 32'hFFFF_FFFF, '0);
    pulse(16'h0010);
    check("R8 rx request not error", {31'd0, err_any}, 32'd0);
    check("R9 rx request not done", {31'd0, done_any}, 32'd0);
    check("R7 irq on rx request", {31'd0, irq}, 32'd1);

    wait_cyc(4);
    check("SB drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule